// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer

This block runs the external bus cycles of a small 8-bit processor with a 16-bit address space. The core asks for one transfer at a time. Each request carries a kind (opcode fetch, memory read, memory write, I/O read or I/O write), an address and a write byte. The sequencer drives the address, the active-low space-select and direction strobes, and four pre-decoded strobes that combine space with direction. For reads it returns the sampled byte with a one-clock completion pulse.

Every cycle takes three states after acceptance. In the first state the address is valid and no strobe is active. In the second state the strobes go active. In the third state the strobes stay active; at the end of this state read data is sampled and the strobes are released. An opcode fetch is a memory read that also drives a fetch marker for its whole length, and its returned byte is tagged as an opcode. The bidirectional data bus is split into an output byte, an output enable and an input byte, so that the pad ring can build the tristate.

Top module: `bus_cycle_seq`

## Requirements
- R1: After a synchronous reset, all strobes (`mreq_n`, `iorq_n`, `rd_n`, `wr_n`, `m1_n`, `memrd_n`, `memwr_n`, `iord_n`, `iowr_n`) are high, `data_oe` and `rsp_done` are low, and `req_ready` is high.
- R2: A request is taken only when `req_ready` is high, `req_valid` is high and `req_kind` is one of 0 = opcode fetch, 1 = memory read, 2 = memory write, 3 = I/O read, 4 = I/O write. Kind codes 5 to 7 are ignored: `req_ready` stays high and no strobe moves.
- R3: One clock after acceptance (state T1), `addr_o` carries the request address, every strobe is inactive and `req_ready` is low.
- R4: During T2 and T3 (two and three clocks after acceptance), `mreq_n` is low for kinds 0, 1 and 2, and `iorq_n` is low for kinds 3 and 4. The two are never low together.
- R5: During T2 and T3, `rd_n` is low for kinds 0, 1 and 3, and `wr_n` is low for kinds 2 and 4. The two are never low together.
- R6: During T2 and T3, exactly one decoded strobe is low: `memrd_n` for kinds 0 and 1, `memwr_n` for kind 2, `iord_n` for kind 3, `iowr_n` for kind 4. All decoded strobes are high at every other time.
- R7: `m1_n` is low from T1 through T3 of an opcode fetch, and high at all other times.
- R8: `data_oe` is high only during T2 and T3 of a write (kinds 2 and 4). While `data_oe` is high, `data_out` equals the request's write byte.
- R9: Four clocks after acceptance, `rsp_done` is high for exactly one clock. At that point `rsp_data` holds `data_in` as sampled at that edge, `rsp_opcode` is 1 only for an opcode fetch, and all strobes are released.
- R10: Requests presented while a cycle is in progress are ignored, and `addr_o` stays stable from T1 through T3.
- R11: A request presented in the clock where `rsp_done` is high is accepted, so back-to-back cycles start every four clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Cycle kind code (0..4 valid) |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| addr_o | output | 16 | Address bus |
| data_out | output | 8 | Data bus output byte |
| data_oe | output | 1 | Data bus output enable |
| data_in | input | 8 | Data bus input byte |
| mreq_n | output | 1 | Memory space strobe, active low |
| iorq_n | output | 1 | I/O space strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m1_n | output | 1 | Opcode fetch marker, active low |
| memrd_n | output | 1 | Decoded memory read, active low |
| memwr_n | output | 1 | Decoded memory write, active low |
| iord_n | output | 1 | Decoded I/O read, active low |
| iowr_n | output | 1 | Decoded I/O write, active low |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_data | output | 8 | Byte read in the finished cycle |
| rsp_opcode | output | 1 | Finished cycle was an opcode fetch |

## Verification
Every output is registered, so results follow a fixed count of edges after the accepting edge. The address and the fetch marker appear after one edge. The strobes and the output enable appear after two edges and remain through the third. The completion pulse, the returned byte and the strobe release appear after four edges. The bench applies each request half a clock before the accepting edge, then samples at the falling edge after each of the following four rising edges, and compares every output with the value computed from the kind code for that state. The byte placed on `data_in` during T2 must come back at the fourth sample, and the pulse must be gone at the next sample.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_T1   = 2'd1,
    ST_T2   = 2'd2,
    ST_T3   = 2'd3
  } phase_e;

  function automatic logic kind_ok(input logic [2:0] k);
    return k <= 3'd4;
  endfunction

  function automatic logic kind_mem(input logic [2:0] k);
    return k <= 3'd2;
  endfunction

  function automatic logic kind_write(input logic [2:0] k);
    return (k == K_MWR) || (k == K_IOWR);
  endfunction

  function automatic logic phase_strobe(input phase_e p);
    return (p == ST_T2) || (p == ST_T3);
  endfunction

endpackage

// File: rtl/bcs_fsm.sv
module bcs_fsm
  import bcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [2:0] req_kind,
  output phase_e     phase_q,
  output phase_e     phase_nxt,
  output logic [2:0] kind_q,
  output logic [2:0] kind_nxt,
  output logic       take
);

  assign take     = (phase_q == ST_IDLE) && req_valid && kind_ok(req_kind);
  assign kind_nxt = take ? req_kind : kind_q;

  always_comb begin
    unique case (phase_q)
      ST_IDLE: phase_nxt = take ? ST_T1 : ST_IDLE;
      ST_T1:   phase_nxt = ST_T2;
      ST_T2:   phase_nxt = ST_T3;
      default: phase_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= ST_IDLE;
      kind_q  <= 3'd0;
    end else begin
      phase_q <= phase_nxt;
      kind_q  <= kind_nxt;
    end
  end

endmodule

// File: rtl/bcs_strobe_gen.sv
module bcs_strobe_gen
  import bcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  phase_e     phase_nxt,
  input  logic [2:0] kind_nxt,
  output logic       mreq_n,
  output logic       iorq_n,
  output logic       rd_n,
  output logic       wr_n,
  output logic       m1_n,
  output logic [3:0] dec_n
);

  localparam int N_SPACE = 2;
  localparam int N_DIR   = 2;

  logic              on;
  logic [N_SPACE-1:0] space_sel;
  logic [N_DIR-1:0]   dir_sel;

  assign on        = phase_strobe(phase_nxt);
  assign space_sel = {on && !kind_mem(kind_nxt), on && kind_mem(kind_nxt)};
  assign dir_sel   = {on && kind_write(kind_nxt), on && !kind_write(kind_nxt)};

  always_ff @(posedge clk) begin
    if (rst) begin
      mreq_n <= 1'b1;
      iorq_n <= 1'b1;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      m1_n   <= 1'b1;
    end else begin
      mreq_n <= !space_sel[0];
      iorq_n <= !space_sel[1];
      rd_n   <= !dir_sel[0];
      wr_n   <= !dir_sel[1];
      m1_n   <= !((phase_nxt != ST_IDLE) && (kind_nxt == K_FETCH));
    end
  end

  // index = space*2 + dir : 0 mem rd, 1 mem wr, 2 io rd, 3 io wr
  for (genvar s = 0; s < N_SPACE; s++) begin : g_space
    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
      always_ff @(posedge clk) begin
        if (rst) dec_n[s*N_DIR+d] <= 1'b1;
        else     dec_n[s*N_DIR+d] <= !(space_sel[s] && dir_sel[d]);
      end
    end
  end

endmodule

// File: rtl/bcs_datapath.sv
module bcs_datapath
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  phase_e            phase_q,
  input  phase_e            phase_nxt,
  input  logic [2:0]        kind_q,
  input  logic [2:0]        kind_nxt,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_opcode
);

  logic last_phase;
  assign last_phase = (phase_q == ST_T3);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o     <= '0;
      data_out   <= '0;
      data_oe    <= 1'b0;
      rsp_done   <= 1'b0;
      rsp_data   <= '0;
      rsp_opcode <= 1'b0;
    end else begin
      if (take) begin
        addr_o   <= req_addr;
        data_out <= req_wdata;
      end
      data_oe  <= phase_strobe(phase_nxt) && kind_write(kind_nxt);
      rsp_done <= last_phase;
      if (last_phase) begin
        rsp_data   <= data_in;
        rsp_opcode <= (kind_q == K_FETCH);
      end
    end
  end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  input  logic [DATA_W-1:0] data_in,
  output logic              mreq_n,
  output logic              iorq_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              m1_n,
  output logic              memrd_n,
  output logic              memwr_n,
  output logic              iord_n,
  output logic              iowr_n,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_opcode
);

  phase_e     phase_q, phase_nxt;
  logic [2:0] kind_q, kind_nxt;
  logic       take;
  logic [3:0] dec_n;

  bcs_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .phase_q   (phase_q),
    .phase_nxt (phase_nxt),
    .kind_q    (kind_q),
    .kind_nxt  (kind_nxt),
    .take      (take)
  );

  bcs_strobe_gen u_strobe (
    .clk       (clk),
    .rst       (rst),
    .phase_nxt (phase_nxt),
    .kind_nxt  (kind_nxt),
    .mreq_n    (mreq_n),
    .iorq_n    (iorq_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .m1_n      (m1_n),
    .dec_n     (dec_n)
  );

  bcs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .take       (take),
    .phase_q    (phase_q),
    .phase_nxt  (phase_nxt),
    .kind_q     (kind_q),
    .kind_nxt   (kind_nxt),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .data_in    (data_in),
    .addr_o     (addr_o),
    .data_out   (data_out),
    .data_oe    (data_oe),
    .rsp_done   (rsp_done),
    .rsp_data   (rsp_data),
    .rsp_opcode (rsp_opcode)
  );

  assign req_ready = (phase_q == ST_IDLE);
  assign memrd_n   = dec_n[0];
  assign memwr_n   = dec_n[1];
  assign iord_n    = dec_n[2];
  assign iowr_n    = dec_n[3];

endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [2:0]        req_kind,
  input logic              req_ready,
  input logic [ADDR_W-1:0] addr_o,
  input logic              data_oe,
  input logic              mreq_n,
  input logic              iorq_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              m1_n,
  input logic              memrd_n,
  input logic              memwr_n,
  input logic              iord_n,
  input logic              iowr_n,
  input logic              rsp_done
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  p_space_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(!mreq_n && !iorq_n));

  p_dir_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  p_dec_single_r6: assert property (@(posedge clk) disable iff (rst)
    $countones({~memrd_n, ~memwr_n, ~iord_n, ~iowr_n}) <= 1);

  p_dec_space_r6: assert property (@(posedge clk) disable iff (rst)
    (!memrd_n || !memwr_n) |-> !mreq_n);

  p_m1_no_io_r7: assert property (@(posedge clk) disable iff (rst)
    !m1_n |-> (iorq_n && wr_n));

  p_oe_write_r8: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> !wr_n);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> (req_ready && mreq_n && iorq_n));

  p_take_r2: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid && req_kind <= 3'd4) |=> !req_ready);

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (rst || !armed)
    (!req_ready && !$past(req_ready)) |-> $stable(addr_o));

endmodule

bind bus_cycle_seq bus_cycle_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .req_ready (req_ready),
  .addr_o    (addr_o),
  .data_oe   (data_oe),
  .mreq_n    (mreq_n),
  .iorq_n    (iorq_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .m1_n      (m1_n),
  .memrd_n   (memrd_n),
  .memwr_n   (memwr_n),
  .iord_n    (iord_n),
  .iowr_n    (iowr_n),
  .rsp_done  (rsp_done)
);

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = 3'd0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  data_in = '0;
  logic        req_ready, data_oe, mreq_n, iorq_n, rd_n, wr_n, m1_n;
  logic        memrd_n, memwr_n, iord_n, iowr_n, rsp_done, rsp_opcode;
  logic [15:0] addr_o;
  logic [7:0]  data_out, rsp_data;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .addr_o(addr_o), .data_out(data_out), .data_oe(data_oe), .data_in(data_in),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n),
    .memrd_n(memrd_n), .memwr_n(memwr_n), .iord_n(iord_n), .iowr_n(iowr_n),
    .rsp_done(rsp_done), .rsp_data(rsp_data), .rsp_opcode(rsp_opcode)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [10:0] strobes();
    return {mreq_n, iorq_n, rd_n, wr_n, m1_n, memrd_n, memwr_n, iord_n, iowr_n,
            data_oe, rsp_done};
  endfunction

  // expected strobe vector for a kind in an active (T2/T3) state
  function automatic logic [10:0] exp_active(input int k);
    bit mem = (k <= 2);
    bit wr  = (k == 2) || (k == 4);
    return {!mem, mem, wr, !wr, !(k == 0), !(mem && !wr), !(mem && wr),
            !(!mem && !wr), !(!mem && wr), wr, 1'b0};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one full cycle; at entry the bench sits at a falling edge with the block idle
  task automatic run_cycle(input int k, input logic [15:0] a, input logic [7:0] d,
                           input logic [7:0] rb, input bit poke_busy);
    logic [10:0] idle_v = {4'hF, 1'b1, 4'hF, 2'b00};
    req_valid = 1'b1; req_kind = 3'(k); req_addr = a; req_wdata = d;
    tick();
    // T1
    chk(addr_o == a, "R3 addr", 32'(addr_o), 32'(a));
    chk(strobes() == {4'hF, !(k == 0), 4'hF, 2'b00}, "R3/R7 T1 strobes",
        32'(strobes()), 32'({4'hF, !(k == 0), 4'hF, 2'b00}));
    chk(req_ready == 1'b0, "R3 ready low", 32'(req_ready), 0);
    if (poke_busy) begin
      req_kind = 3'((k + 1) % 5); req_addr = ~a;
    end else req_valid = 1'b0;
    tick();
    // T2
    chk(strobes() == exp_active(k), "R4/R5/R6/R8 T2 strobes",
        32'(strobes()), 32'(exp_active(k)));
    if (k == 2 || k == 4) chk(data_out == d, "R8 data_out", 32'(data_out), 32'(d));
    data_in = rb;
    tick();
    // T3
    chk(strobes() == exp_active(k), "R4/R5/R6/R8 T3 strobes",
        32'(strobes()), 32'(exp_active(k)));
    chk(addr_o == a, "R10 addr held", 32'(addr_o), 32'(a));
    req_valid = 1'b0;
    tick();
    // completion
    chk(strobes() == {idle_v[10:1], 1'b1}, "R9 done/release",
        32'(strobes()), 32'({idle_v[10:1], 1'b1}));
    chk(rsp_data == rb, "R9 rsp_data", 32'(rsp_data), 32'(rb));
    chk(rsp_opcode == (k == 0), "R9 rsp_opcode", 32'(rsp_opcode), 32'(k == 0));
    chk(req_ready == 1'b1, "R11 ready with done", 32'(req_ready), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] addrs [4] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h1E78};
    logic [7:0]  bytes [4] = '{8'h00, 8'hFF, 8'h5A, 8'hC3};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(strobes() == {4'hF, 1'b1, 4'hF, 2'b00}, "R1 reset strobes",
        32'(strobes()), 32'({4'hF, 1'b1, 4'hF, 2'b00}));
    chk(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 1);

    // R2: kinds 5..7 ignored
    for (int k = 5; k < 8; k++) begin
      req_valid = 1'b1; req_kind = 3'(k); req_addr = 16'h1234;
      tick();
      req_valid = 1'b0;
      chk(req_ready == 1'b1, "R2 invalid kind ignored", 32'(req_ready), 1);
      tick();
      chk(strobes() == {4'hF, 1'b1, 4'hF, 2'b00}, "R2 no strobes for bad kind",
          32'(strobes()), 32'({4'hF, 1'b1, 4'hF, 2'b00}));
      tick();
      chk(rsp_done == 1'b0, "R2 no done for bad kind", 32'(rsp_done), 0);
    end

    // sweep all kinds, back-to-back (R11), with busy pokes on odd patterns (R10)
    for (int k = 0; k < 5; k++)
      for (int p = 0; p < 4; p++)
        run_cycle(k, addrs[p] ^ 16'(k * 16'h0101), bytes[p] ^ 8'(k),
                  bytes[3 - p] ^ 8'(p * 17), p[0]);

    // after the final completion no extra cycle starts (R10, R9 pulse width)
    tick();
    chk(rsp_done == 1'b0, "R9 single pulse", 32'(rsp_done), 0);
    chk(req_ready == 1'b1, "R10 no phantom cycle", 32'(req_ready), 1);
    tick();
    chk(strobes() == {4'hF, 1'b1, 4'hF, 2'b00}, "R10 idle strobes",
        32'(strobes()), 32'({4'hF, 1'b1, 4'hF, 2'b00}));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule